// File: doc/BRIEF.md
# Coincident-Selection Bit-Cell RAM

This block is a small random-access store of single-bit words. The storage cells sit in a two-dimensional grid of rows and columns. The upper address bits pick a row and the lower address bits pick a column. A cell is reached only where a live row line crosses a live column line. Because of this, two small decoders are enough, and no flat decoder with one line per word is needed. The chip select drives the enable input of the column decoder. When the chip is not selected, every column line stays inactive, so no cell can be written and no column puts data on the read path.

Each column has its own read/write slice. It writes the incoming bit into the crossed cell on a clock edge when the block is in write mode. In read mode it passes the crossed cell's value onward without delay. The single data output is a three-state driver. It is driven only while the chip is selected and in read mode, so several of these blocks can share one output wire. With the default parameters, the grid is 4 rows by 4 columns and holds 16 words.

Top module: `csram_array`

## Requirements
- R1: After reset every cell holds 0, so a read of any address returns 0.
- R2: With chip_sel=1 and wr_mode=1 (write), the rising clock edge stores wdata in the cell at row addr[3:2], column addr[1:0]. This is word index row*4+column, which equals the address value.
- R3: A write changes only the addressed cell. Every other cell keeps its value.
- R4: With chip_sel=1 and wr_mode=0 (read), rdata shows the addressed cell in the same cycle, with no clock edge in between.
- R5: With chip_sel=0, no cell changes, whatever the values of wr_mode, wdata and addr.
- R6: rdata is high-impedance whenever chip_sel=0, and also during write mode. This lets another driver on the same wire set its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset that clears all cells |
| addr | input | 4 | Word address; upper bits pick the row, lower bits the column |
| wdata | input | 1 | Bit to be written |
| wr_mode | input | 1 | 1 = write, 0 = read |
| chip_sel | input | 1 | Chip select; drives the column decoder enable |
| rdata | output | 1 | Three-state read data |

## Verification
The bench reads all sixteen addresses after each stage. A swapped row/column split, or a decoder that fires more than one line, would put data at the wrong index or copy it into a neighbour cell. A single write followed by a sweep shows whether neighbours in the same row or column were disturbed. The bench then writes inverted data into every address while the chip is deselected; a column decoder that ignores its enable would corrupt the whole pattern. Finally, the bench drives the shared output wire itself with both levels while the block is deselected and while it is writing. If the block kept its driver on, the wire would disagree with the bench's level at least once.

// File: rtl/csram_pkg.sv
package csram_pkg;

   typedef enum logic {
      MODE_READ  = 1'b0,
      MODE_WRITE = 1'b1
   } csram_mode_e;

endpackage

// File: rtl/csram_decoder.sv
module csram_decoder #(
   parameter int SEL_BITS = 2,
   parameter bit HAS_EN   = 1'b0,
   localparam int LINES   = 1 << SEL_BITS
) (
   input  logic [SEL_BITS-1:0] sel,
   input  logic                en,
   output logic [LINES-1:0]    lines
);

   if (SEL_BITS < 1) begin : g_bad_width
      $error("csram_decoder: SEL_BITS must be at least 1");
   end

   if (HAS_EN) begin : g_gated
      always_comb begin
         lines = '0;
         for (int i = 0; i < LINES; i++) begin
            if (en && (sel == SEL_BITS'(i))) lines[i] = 1'b1;
         end
      end
   end else begin : g_free
      logic unused_en;
      assign unused_en = en;
      always_comb begin
         lines = '0;
         for (int i = 0; i < LINES; i++) begin
            if (sel == SEL_BITS'(i)) lines[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/csram_cell.sv
module csram_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic row_on,
   input  logic col_on,
   input  logic wr,
   input  logic d,
   output logic q
);

   logic hit;
   assign hit = row_on & col_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (hit && wr) q <= d;
   end

   // R2
   cell_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_on && col_on && wr) |=> (q == $past(d)));

   // R3
   cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(row_on && col_on && wr) |=> $stable(q));

endmodule

// File: rtl/csram_column.sv
module csram_column #(
   parameter int ROWS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ROWS-1:0] row_lines,
   input  logic            col_line,
   input  logic            wr,
   input  logic            d,
   output logic            rd
);

   if (ROWS < 2) begin : g_bad_rows
      $error("csram_column: ROWS must be at least 2");
   end

   logic [ROWS-1:0] cells;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      csram_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .row_on (row_lines[r]),
         .col_on (col_line),
         .wr     (wr),
         .d      (d),
         .q      (cells[r])
      );
   end

   assign rd = col_line & (|(cells & row_lines));

   // R5
   col_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !col_line |=> $stable(cells));

endmodule

// File: rtl/csram_array.sv
module csram_array #(
   parameter int ROW_BITS = 2,
   parameter int COL_BITS = 2,
   localparam int ADDR_W  = ROW_BITS + COL_BITS,
   localparam int ROWS    = 1 << ROW_BITS,
   localparam int COLS    = 1 << COL_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wdata,
   input  logic              wr_mode,
   input  logic              chip_sel,
   output logic              rdata
);
   import csram_pkg::*;

   if (ADDR_W > 10) begin : g_too_big
      $error("csram_array: grid too large for a bit-cell array");
   end

   logic [ROWS-1:0] row_lines;
   logic [COLS-1:0] col_lines;
   logic [COLS-1:0] col_rd;
   logic            is_write;
   logic            drive;

   assign is_write = (csram_mode_e'(wr_mode) == MODE_WRITE);

   csram_decoder #(.SEL_BITS(ROW_BITS), .HAS_EN(1'b0)) u_row_dec (
      .sel   (addr[ADDR_W-1:COL_BITS]),
      .en    (1'b1),
      .lines (row_lines)
   );

   csram_decoder #(.SEL_BITS(COL_BITS), .HAS_EN(1'b1)) u_col_dec (
      .sel   (addr[COL_BITS-1:0]),
      .en    (chip_sel),
      .lines (col_lines)
   );

   for (genvar c = 0; c < COLS; c++) begin : g_col
      csram_column #(.ROWS(ROWS)) u_col (
         .clk       (clk),
         .rst_n     (rst_n),
         .row_lines (row_lines),
         .col_line  (col_lines[c]),
         .wr        (is_write),
         .d         (wdata),
         .rd        (col_rd[c])
      );
   end

   assign drive = chip_sel & ~is_write;
   assign rdata = drive ? (|col_rd) : 1'bz;

   // R4
   one_col_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_rd));

   // R5
   desel_cols_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_sel |-> (col_lines == '0));

   // R2
   sel_one_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chip_sel |-> ($countones(col_lines) == 1));

endmodule

// File: tb/tb_csram_array.sv
`timescale 1ns/1ps
module tb_csram_array;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wdata = 1'b0;
   logic       wr_mode = 1'b0;
   logic       chip_sel = 1'b0;
   logic       tb_en = 1'b0;
   logic       tb_val = 1'b0;
   wire        bus;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit model [16];

   always #10 clk = ~clk;

   assign bus = tb_en ? tb_val : 1'bz;

   csram_array dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .wdata    (wdata),
      .wr_mode  (wr_mode),
      .chip_sel (chip_sel),
      .rdata    (bus)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s addr=%0d actual=%b expected=%b", req, addr, act, exp);
      end
   endtask

   task automatic wr_cycle(input int a, input bit d, input bit cs);
      @(negedge clk);
      addr = 4'(a); wdata = d; wr_mode = 1'b1; chip_sel = cs;
      @(posedge clk);
      if (cs) model[a] = d;
   endtask

   task automatic rd_cycle(input int a, input string req);
      @(negedge clk);
      addr = 4'(a); wr_mode = 1'b0; chip_sel = 1'b1; tb_en = 1'b0;
      #3 check(req, bus, model[a]);
   endtask

   task automatic sweep(input string req);
      for (int a = 0; a < 16; a++) rd_cycle(a, req);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 16; a++) model[a] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: cleared contents, R4: same-cycle read
      sweep("R1");

      // R2: store a pattern at index row*4+col
      for (int a = 0; a < 16; a++) wr_cycle(a, bit'((a % 3 == 0) ^ (a > 9)), 1'b1);
      sweep("R2");

      // R3: single write leaves neighbours untouched
      wr_cycle(6, ~model[6], 1'b1);
      sweep("R3");
      wr_cycle(9, ~model[9], 1'b1);
      sweep("R3");

      // R4: immediate read after address change, no edge
      @(negedge clk);
      addr = 4'd3; wr_mode = 1'b0; chip_sel = 1'b1;
      #2 check("R4", bus, model[3]);
      addr = 4'd6;
      #2 check("R4", bus, model[6]);

      // R5: deselected writes of inverted data change nothing
      for (int a = 0; a < 16; a++) begin
         @(negedge clk);
         addr = 4'(a); wdata = ~model[a]; wr_mode = 1'b1; chip_sel = 1'b0;
         @(posedge clk);
      end
      sweep("R5");

      // R6: output released when deselected (read mode) and when writing
      for (int a = 0; a < 16; a++) begin
         for (int v = 0; v < 2; v++) begin
            @(negedge clk);
            addr = 4'(a); wr_mode = 1'b0; chip_sel = 1'b0;
            tb_en = 1'b1; tb_val = v[0];
            #3 check("R6", bus, v[0]);
            @(negedge clk);
            wr_mode = 1'b1; chip_sel = 1'b1; wdata = model[a];
            tb_val = v[0];
            #3 check("R6", bus, v[0]);
         end
      end
      @(negedge clk);
      tb_en = 1'b0; chip_sel = 1'b0; wr_mode = 1'b0;
      sweep("R6");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule